// File: doc/BRIEF.md
# Trimmed Real-Time Clock

This block keeps wall time as a plain count of seconds. It runs on a 32.768 kHz clock. A prescaler counts that clock and makes one tick per second. Its period comes from a divider value plus a trim correction, and the trim lets software make up for a crystal that runs slightly fast or slow. Each tick advances a 32-bit seconds counter. The counter is compared against a 32-bit alarm value.

A small control/status word holds two sticky event flags, one for the tick and one for the alarm. Software clears a flag by writing a one to its bit. The word also holds one enable per flag. Each flag, ANDed with its enable, drives its own level interrupt line.

Software reaches the registers over a simple synchronous write bus with an address-decoded, combinational read path. Two register layouts are supported, and a parameter picks one of them.

Top module: `rtc_trim_core`

## Requirements
- R1: After reset, the counter and alarm read 0, the control/status word reads 0, and the trim/divider register reads 0x0000_7FFF. With these reset settings the counter first advances about 32768 clock cycles after reset is released.
- R2: With ALT_MAP=0 the registers are at these addresses: counter 0x00, alarm 0x04, control/status 0x08, trim/divider 0x0C. With ALT_MAP=1 they are at: alarm 0x00, counter 0x04, trim/divider 0x08, control/status 0x10. A read from any other address returns 0.
- R3: The trim/divider register holds the divider in bits 15:0 and the trim in bits 31:16. The counter advances once every divider+trim+1 clock cycles. A write to this register restarts the prescaler, so the first advance after the write comes divider+trim+2 cycles after the write edge.
- R4: Software can write the counter. If a write and a tick fall in the same cycle, the written value wins. The counter wraps from 0xFFFF_FFFF to 0.
- R5: The alarm flag (bit 0 of the control/status word) sets in the first cycle that the counter equals the alarm value. Equality can begin through a tick or through a write to either register. The flag does not set again while equality merely continues, and the equality present at reset does not set it.
- R6: The tick flag (bit 1) sets on every prescaler tick, in the same cycle that the counter advances.
- R7: Writing 1 to bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. Bit 2 (alarm enable) and bit 3 (tick enable) are ordinary read/write bits. Bits 31:4 always read 0.
- R8: If a flag is set and cleared in the same cycle, the set wins and the flag stays 1.
- R9: irq_alarm is the alarm flag AND bit 2, and irq_tick is the tick flag AND bit 3. Both are level outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time base, also used as the bus clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_wr | input | 1 | write strobe, sampled on the rising clock edge |
| bus_addr | input | 5 | byte address of the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for bus_addr, combinational |
| irq_tick | output | 1 | level interrupt: tick flag AND tick enable |
| irq_alarm | output | 1 | level interrupt: alarm flag AND alarm enable |

## Verification
The hardest situation to reach is a tick that lands in exactly the cycle in which software clears the tick flag. At normal rates the two almost never meet. The bench therefore programs divider 0 and trim 0, so the prescaler ticks on every cycle, and then issues the clear; the flag must still read 1 afterwards. The same trick of short, known periods places the alarm match a fixed number of cycles after a restarting trim/divider write, so the edge-only alarm set can be sampled in its exact cycle.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

   // Register selector produced by the address decoder.
   typedef enum logic [1:0] {
      REG_CNT = 2'd0,
      REG_ALM = 2'd1,
      REG_CTL = 2'd2,
      REG_TD  = 2'd3
   } rtc_reg_e;

   // Control/status word. Bit positions are software-visible:
   // 0 alarm flag, 1 tick flag, 2 alarm enable, 3 tick enable.
   typedef struct packed {
      logic tick_en;
      logic alarm_en;
      logic tick_flag;
      logic alarm_flag;
   } rtc_ctl_t;

   localparam int unsigned CTL_W = $bits(rtc_ctl_t);

   // Standard layout
   localparam int unsigned MAP0_CNT = 'h00;
   localparam int unsigned MAP0_ALM = 'h04;
   localparam int unsigned MAP0_CTL = 'h08;
   localparam int unsigned MAP0_TD  = 'h0C;

   // Alternate layout
   localparam int unsigned MAP1_ALM = 'h00;
   localparam int unsigned MAP1_CNT = 'h04;
   localparam int unsigned MAP1_TD  = 'h08;
   localparam int unsigned MAP1_CTL = 'h10;

endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
   import rtc_trim_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter bit          ALT_MAP = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output rtc_reg_e          sel,
   output logic              hit
);

   generate
      if (ALT_MAP) begin : g_alt_map
         always_comb begin
            hit = 1'b1;
            sel = REG_CNT;
            if      (addr == ADDR_W'(MAP1_ALM)) sel = REG_ALM;
            else if (addr == ADDR_W'(MAP1_CNT)) sel = REG_CNT;
            else if (addr == ADDR_W'(MAP1_TD))  sel = REG_TD;
            else if (addr == ADDR_W'(MAP1_CTL)) sel = REG_CTL;
            else                                hit = 1'b0;
         end
      end else begin : g_std_map
         always_comb begin
            hit = 1'b1;
            sel = REG_CNT;
            if      (addr == ADDR_W'(MAP0_CNT)) sel = REG_CNT;
            else if (addr == ADDR_W'(MAP0_ALM)) sel = REG_ALM;
            else if (addr == ADDR_W'(MAP0_CTL)) sel = REG_CTL;
            else if (addr == ADDR_W'(MAP0_TD))  sel = REG_TD;
            else                                hit = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned TRIM_W   = 16,
   parameter int unsigned RST_DIV  = 32767,
   parameter int unsigned RST_TRIM = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [TRIM_W-1:0] cfg_trim,
   output logic [DIV_W-1:0]  div_q,
   output logic [TRIM_W-1:0] trim_q,
   output logic              tick
);

   localparam int unsigned LIM_W = ((DIV_W > TRIM_W) ? DIV_W : TRIM_W) + 1;

   logic [LIM_W-1:0] cnt;
   logic [LIM_W-1:0] limit;

   // The period is divider + trim + 1 input cycles.
   assign limit = LIM_W'(div_q) + LIM_W'(trim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= DIV_W'(RST_DIV);
         trim_q <= TRIM_W'(RST_TRIM);
         cnt    <= '0;
         tick   <= 1'b0;
      end else if (cfg_we) begin
         div_q  <= cfg_div;
         trim_q <= cfg_trim;
         cnt    <= '0;
         tick   <= 1'b0;
      end else if (cnt == limit) begin
         cnt    <= '0;
         tick   <= 1'b1;
      end else begin
         cnt    <= cnt + LIM_W'(1);
         tick   <= 1'b0;
      end
   end

   // R3: a restart leaves the prescaler idle for the next cycle
   a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cnt == '0 && !tick));

   // R3: ticks are isolated whenever the period exceeds one cycle
   a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && limit != '0 && !cfg_we) |=> !tick);

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_we,
   input  logic             alm_we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] seconds,
   output logic [CNT_W-1:0] alarm,
   output logic             alarm_hit
);

   logic match;
   logic match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seconds <= '0;
      end else if (cnt_we) begin
         seconds <= wdata;
      end else if (tick) begin
         seconds <= seconds + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm <= '0;
      end else if (alm_we) begin
         alarm <= wdata;
      end
   end

   assign match = (seconds == alarm);

   // Start at 1 so that the equality present at reset is not an event.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b1;
      else        match_q <= match;
   end

   assign alarm_hit = match & ~match_q;

   // R4: an unwritten tick adds exactly one, with wrap
   a_r4_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_we) |=> seconds == $past(seconds) + CNT_W'(1));

   // R4: a write lands even when a tick coincides
   a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> seconds == $past(wdata));

   // R5: the alarm event is a single-cycle pulse
   a_r5_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> !alarm_hit);

endmodule

// File: rtl/rtc_event_status.sv
module rtc_event_status
   import rtc_trim_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] wdata,
   input  logic             set_alarm,
   input  logic             set_tick,
   output rtc_ctl_t         ctl,
   output logic             irq_alarm,
   output logic             irq_tick
);

   rtc_ctl_t wr;
   logic     clr_alarm;
   logic     clr_tick;

   assign wr        = rtc_ctl_t'(wdata);
   assign clr_alarm = ctl_we & wr.alarm_flag;
   assign clr_tick  = ctl_we & wr.tick_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         // A set beats a clear that arrives in the same cycle.
         ctl.alarm_flag <= set_alarm | (ctl.alarm_flag & ~clr_alarm);
         ctl.tick_flag  <= set_tick  | (ctl.tick_flag  & ~clr_tick);
         if (ctl_we) begin
            ctl.alarm_en <= wr.alarm_en;
            ctl.tick_en  <= wr.tick_en;
         end
      end
   end

   assign irq_alarm = ctl.alarm_flag & ctl.alarm_en;
   assign irq_tick  = ctl.tick_flag  & ctl.tick_en;

   // R8: set wins over a simultaneous clear
   a_r8_alarm_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_alarm |=> ctl.alarm_flag);
   a_r8_tick_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_tick |=> ctl.tick_flag);

   // R7: a flag only drops on a one written to its bit
   a_r7_tick_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.tick_flag && !clr_tick) |=> ctl.tick_flag);
   a_r7_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_alarm && !set_alarm) |=> !ctl.alarm_flag);

   // R9: an interrupt line never rises without its enable
   a_r9_alarm_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_alarm |-> ctl.alarm_en);

endmodule

// File: rtl/rtc_trim_core.sv
module rtc_trim_core
   import rtc_trim_pkg::*;
#(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned TRIM_W   = 16,
   parameter int unsigned RST_DIV  = 32767,
   parameter int unsigned RST_TRIM = 0,
   parameter bit          ALT_MAP  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_tick,
   output logic              irq_alarm
);

   // Elaboration-time parameter checks
   generate
      if (DIV_W + TRIM_W > DATA_W) begin : g_bad_td
         $error("trim and divider fields do not fit the data word");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("counter wider than the data word");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("address too narrow for the register layouts");
      end
      if (DIV_W == 0 || TRIM_W == 0) begin : g_bad_fields
         $error("divider and trim fields need at least one bit");
      end
   endgenerate

   rtc_reg_e         sel;
   logic             hit;
   logic             we_cnt, we_alm, we_ctl, we_td;
   logic [DIV_W-1:0] div_q;
   logic [TRIM_W-1:0] trim_q;
   logic             tick;
   logic [CNT_W-1:0] seconds;
   logic [CNT_W-1:0] alarm;
   logic             alarm_hit;
   rtc_ctl_t         ctl;

   rtc_addr_decode #(
      .ADDR_W  (ADDR_W),
      .ALT_MAP (ALT_MAP)
   ) u_decode (
      .addr (bus_addr),
      .sel  (sel),
      .hit  (hit)
   );

   assign we_cnt = bus_wr & hit & (sel == REG_CNT);
   assign we_alm = bus_wr & hit & (sel == REG_ALM);
   assign we_ctl = bus_wr & hit & (sel == REG_CTL);
   assign we_td  = bus_wr & hit & (sel == REG_TD);

   rtc_prescaler #(
      .DIV_W    (DIV_W),
      .TRIM_W   (TRIM_W),
      .RST_DIV  (RST_DIV),
      .RST_TRIM (RST_TRIM)
   ) u_prescaler (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (we_td),
      .cfg_div  (bus_wdata[DIV_W-1:0]),
      .cfg_trim (bus_wdata[DIV_W +: TRIM_W]),
      .div_q    (div_q),
      .trim_q   (trim_q),
      .tick     (tick)
   );

   rtc_sec_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cnt_we    (we_cnt),
      .alm_we    (we_alm),
      .wdata     (bus_wdata[CNT_W-1:0]),
      .seconds   (seconds),
      .alarm     (alarm),
      .alarm_hit (alarm_hit)
   );

   rtc_event_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (we_ctl),
      .wdata     (bus_wdata[CTL_W-1:0]),
      .set_alarm (alarm_hit),
      .set_tick  (tick),
      .ctl       (ctl),
      .irq_alarm (irq_alarm),
      .irq_tick  (irq_tick)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (sel)
            REG_CNT: bus_rdata[CNT_W-1:0] = seconds;
            REG_ALM: bus_rdata[CNT_W-1:0] = alarm;
            REG_CTL: bus_rdata[CTL_W-1:0] = ctl;
            REG_TD: begin
               bus_rdata[DIV_W-1:0]       = div_q;
               bus_rdata[DIV_W +: TRIM_W] = trim_q;
            end
            default: bus_rdata = '0;
         endcase
      end
   end

   // R6: the tick flag follows every counter advance
   a_r6_tick_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !we_cnt) |=> (ctl.tick_flag && seconds == $past(seconds) + CNT_W'(1)));

   // R2: unmapped addresses read as zero
   a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> bus_rdata == '0);

endmodule

// File: tb/test_rtc_trim_core.sv
`timescale 1ns/1ps
module test_rtc_trim_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        alt_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, alt_rdata;
   logic        irq_tick, irq_alarm, alt_irq_tick, alt_irq_alarm;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   rtc_trim_core i_rtc_trim_core (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .irq_tick (irq_tick), .irq_alarm (irq_alarm)
   );

   rtc_trim_core #(.ALT_MAP (1'b1)) i_rtc_alt (
      .clk (clk), .rst_n (rst_n), .bus_wr (alt_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (alt_rdata),
      .irq_tick (alt_irq_tick), .irq_alarm (alt_irq_alarm)
   );

   localparam logic [4:0] A_CNT = 5'h00, A_ALM = 5'h04, A_CTL = 5'h08, A_TD = 5'h0C;

   // Prescaler vectors: trim/divider word and expected period in cycles
   localparam int NVEC = 5;
   localparam logic [31:0] VEC_TD  [NVEC] = '{32'h0000_0003, 32'h0002_0007,
                                             32'h0000_0000, 32'h0003_0005, 32'h0001_0000};
   localparam int          VEC_PER [NVEC] = '{4, 10, 1, 9, 2};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input bit alt, input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d;
      if (alt) alt_wr = 1'b1; else bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; alt_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic rd_alt(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = alt_rdata;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(150000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v, c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R2 layout
      rd(A_CNT, v); check("R1 counter", v, 0);
      rd(A_ALM, v); check("R1 alarm", v, 0);
      rd(A_CTL, v); check("R1 status", v, 0);
      rd(A_TD, v);  check("R1 trimdiv", v, 32'h0000_7FFF);
      check("R1 irqs", {30'd0, irq_tick, irq_alarm}, 0);
      rd(5'h14, v); check("R2 unmapped", v, 0);

      // R2 alternate layout
      wr(1'b1, 5'h04, 32'h1234);
      rd_alt(5'h04, v); check("R2 alt counter", v, 32'h1234);
      rd_alt(5'h00, v); check("R2 alt alarm", v, 0);
      rd_alt(5'h08, v); check("R2 alt trimdiv", v, 32'h7FFF);
      rd_alt(5'h10, v); check("R2 alt status", v, 0);
      rd(A_CNT, v);     check("R2 std counter untouched", v, 0);

      // R1/R3 default divider: first advance near 32768 cycles
      repeat (31900) @(negedge clk);
      rd(A_CNT, v); check("R1 before first second", v, 0);
      repeat (1000) @(negedge clk);
      rd(A_CNT, v); check("R1 after first second", v, 1);

      // R3 vector table
      for (int i = 0; i < NVEC; i++) begin
         wr(1'b0, A_TD, VEC_TD[i]);
         rd(A_TD, v); check("R3 trimdiv readback", v, VEC_TD[i]);
         rd(A_CNT, c0);
         repeat (VEC_PER[i]) @(negedge clk);
         rd(A_CNT, v); check("R3 no advance yet", v, c0);
         @(negedge clk);
         rd(A_CNT, v); check("R3 first advance", v, c0 + 1);
         repeat (VEC_PER[i] - 1) @(negedge clk);
         rd(A_CNT, v); check("R3 period hold", v, c0 + 1);
         @(negedge clk);
         rd(A_CNT, v); check("R3 second advance", v, c0 + 2);
      end

      // R4 write wins over a tick every cycle
      wr(1'b0, A_TD, 32'h0);
      wr(1'b0, A_CNT, 32'd50);
      rd(A_CNT, v); check("R4 write beats tick", v, 32'd50);

      // R4 wrap
      wr(1'b0, A_TD, 32'h3);
      wr(1'b0, A_CNT, 32'hFFFF_FFFF);
      rd(A_CNT, v); check("R4 loaded max", v, 32'hFFFF_FFFF);
      repeat (3) @(negedge clk);
      rd(A_CNT, v); check("R4 wrap to zero", v, 0);

      // R6/R7/R9 tick flag with slow period 256
      wr(1'b0, A_TD, 32'h0000_00FF);
      wr(1'b0, A_CTL, 32'h3);
      repeat (258) @(negedge clk);
      rd(A_CTL, v); check("R6 tick flag set", v, 32'h2);
      check("R9 irq_tick gated off", {31'd0, irq_tick}, 0);
      wr(1'b0, A_CTL, 32'h8);
      rd(A_CTL, v); check("R7 zero write keeps flag", v, 32'hA);
      check("R9 irq_tick on", {31'd0, irq_tick}, 1);
      wr(1'b0, A_CTL, 32'hA);
      rd(A_CTL, v); check("R7 tick flag cleared", v, 32'h8);
      check("R9 irq_tick off after clear", {31'd0, irq_tick}, 0);

      // R8 set wins: tick every cycle, clear in the same cycle
      wr(1'b0, A_TD, 32'h0);
      wr(1'b0, A_CTL, 32'h2);
      rd(A_CTL, v); check("R8 tick set beats clear", v & 32'h2, 32'h2);

      // R5 alarm via counter write
      wr(1'b0, A_TD, 32'h0000_0FFF);
      wr(1'b0, A_CTL, 32'h3);
      wr(1'b0, A_ALM, 32'd500);
      wr(1'b0, A_CNT, 32'd500);
      rd(A_CTL, v); check("R5 flag not yet", v, 0);
      @(negedge clk);
      rd(A_CTL, v); check("R5 flag on match", v, 32'h1);
      check("R9 irq_alarm gated off", {31'd0, irq_alarm}, 0);
      wr(1'b0, A_CTL, 32'h4);
      rd(A_CTL, v); check("R7 alarm enable", v, 32'h5);
      check("R9 irq_alarm on", {31'd0, irq_alarm}, 1);
      wr(1'b0, A_CTL, 32'h5);
      rd(A_CTL, v); check("R7 alarm flag cleared", v, 32'h4);
      @(negedge clk);
      rd(A_CTL, v); check("R5 no re-set on held match", v, 32'h4);
      check("R9 irq_alarm off", {31'd0, irq_alarm}, 0);

      // R5 alarm reached by ticking
      wr(1'b0, A_TD, 32'h3);
      wr(1'b0, A_CNT, 32'd600);
      wr(1'b0, A_ALM, 32'd602);
      rd(A_CTL, v); check("R5 before tick match", v & 32'h1, 0);
      repeat (8) @(negedge clk);
      rd(A_CNT, v); check("R5 counter at alarm", v, 32'd602);
      rd(A_CTL, v); check("R5 flag via tick", v & 32'h1, 32'h1);
      check("R9 irq_alarm via tick", {31'd0, irq_alarm}, 1);

      // R7 upper bits read zero
      wr(1'b0, A_CTL, 32'hFFFF_FFF0);
      rd(A_CTL, v); check("R7 upper bits zero", v & 32'hFFFF_FFF0, 0);
      check("R9 both irqs off", {30'd0, irq_tick, irq_alarm}, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule